// File: doc/BRIEF.md
# Port Error Flag Banks with Saturating Event Counters

This block keeps the error bookkeeping for one serial port. Each received frame is reported with a 4-bit vector of the error types found in it. The four types are frame, checksum, malformed protocol frame and line error. A sliding record of the last frames lets the block know, at any moment, which error types occurred recently. The port monitor raises a pulse when the port enters error state and another when it recovers. On entry, the block captures the recent error types into an actual flag bank. It also ORs them into a historical bank, which keeps sporadic errors visible until a bus master acknowledges them.

The master can try to clear historical bits. A clear only succeeds where the matching actual bit is false. Two summary bits feed the response path: one is high when any historical flag is up, the other when any actual flag is up. Each error type also has an 8-bit event counter. The counter counts every reported error, whatever the port state, stops at its maximum and returns to zero only on a master reset request.

Top module: `err_flag_reg`

## Requirements
- R1: After synchronous reset, both flag banks, both summary bits and all four counters read zero.
- R2: Error-type bit i of `frm_err` (bit 0 frame, bit 1 checksum, bit 2 malformed frame, bit 3 line) counts only in a cycle with `frm_vld` high. The recent window is the last 16 valid frames, and it includes a frame presented in the same cycle as `enter_err`.
- R3: On `enter_err`, `act_flags` becomes, one cycle later, exactly the set of types present in the window. `hist_flags` gains the same bits in that same cycle.
- R4: On `leave_err` without `enter_err`, both banks are all zero one cycle later. If both pulses arrive together, `enter_err` wins.
- R5: A `hist_wr` with a 0 in bit i clears historical bit i one cycle later only if actual bit i is false at the write. A 1 in the data leaves the bit unchanged, and `act_flags` is never changed by a write.
- R6: When a master clear and a capture on `enter_err` hit the same historical bit in the same cycle, the bit ends up set.
- R7: `hist_any` is high exactly when some historical bit is high, and `act_any` when some actual bit is high.
- R8: Counter i (`cnt_flat[8*i+7:8*i]`) increments by one for each valid frame with error bit i set, in any port state.
- R9: A counter holds at 255 instead of wrapping. `cnt_clr[i]` sets counter i to zero one cycle later, and this overrides an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | One frame finished this cycle |
| frm_err | input | 4 | Error types found in that frame |
| enter_err | input | 1 | Port monitor moves the port into error state |
| leave_err | input | 1 | Port monitor returns the port to non-error state |
| hist_wr | input | 1 | Master write to the historical bank |
| hist_wdata | input | 4 | Write data; a 0 requests clearing that bit |
| cnt_clr | input | 4 | Per-type counter reset request |
| act_flags | output | 4 | Actual error bank |
| hist_flags | output | 4 | Historical error bank |
| act_any | output | 1 | Any actual flag set |
| hist_any | output | 1 | Any historical flag set |
| cnt_flat | output | 32 | Four 8-bit event counters, type i at bits 8i+7..8i |

## Verification
A stale or mis-shifted window entry shows up only at the next `enter_err`. It appears as an extra or missing actual bit, so the bench places captures exactly at the 16th and 17th frame after an error. A bad historical bit shows on `hist_flags` and `hist_any` one cycle after a write or capture that should have moved it. A counter that wraps or misses a clear is visible on `cnt_flat` at the very next cycle.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int NTYPE = 4;
  localparam int WIN   = 16;
  localparam int CW    = 8;
  typedef logic [NTYPE-1:0] type_vec_t;
endpackage

// File: rtl/efr_window.sv
module efr_window #(
  parameter int NT  = 4,
  parameter int WIN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_vld,
  input  logic [NT-1:0] frm_err,
  output logic [NT-1:0] seen_o
);
  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_type
      logic [WIN-1:0] hist_q;
      logic [WIN-1:0] hist_n;
      always_comb begin
        hist_n = hist_q;
        if (frm_vld) hist_n = {hist_q[WIN-2:0], frm_err[g]};
      end
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_n;
      end
      assign seen_o[g] = |hist_n;
    end
  endgenerate
endmodule

// File: rtl/efr_sat_cnt.sv
module efr_sat_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)               cnt <= '0;
    else if (inc && cnt != TOP)   cnt <= cnt + 1'b1;
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !clr) |=> cnt == TOP);
  // R8
  no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/efr_banks.sv
module efr_banks #(
  parameter int NT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] seen,
  input  logic          enter_err,
  input  logic          leave_err,
  input  logic          hist_wr,
  input  logic [NT-1:0] hist_wdata,
  output logic [NT-1:0] act_q,
  output logic [NT-1:0] hist_q,
  output logic          act_any,
  output logic          hist_any
);
  logic [NT-1:0] act_n, hist_n, clr_mask;

  always_comb begin
    clr_mask = hist_wr ? (~hist_wdata & ~act_q) : '0;
    act_n    = act_q;
    hist_n   = hist_q & ~clr_mask;
    if (enter_err) begin
      act_n  = seen;
      hist_n = hist_n | seen;
    end else if (leave_err) begin
      act_n  = '0;
      hist_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      hist_q   <= '0;
      act_any  <= 1'b0;
      hist_any <= 1'b0;
    end else begin
      act_q    <= act_n;
      hist_q   <= hist_n;
      act_any  <= |act_n;
      hist_any <= |hist_n;
    end
  end

  // R5
  act_in_hist_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q & ~hist_q) == '0);
  // R4
  leave_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (leave_err && !enter_err) |=> (act_q == '0 && hist_q == '0));
  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enter_err && !leave_err) |=> $stable(act_q));
  // R3
  hist_grow_chk: assert property (@(posedge clk) disable iff (rst)
    enter_err |=> ((hist_q & $past(seen)) == $past(seen)));
endmodule

// File: rtl/err_flag_reg.sv
module err_flag_reg
  import efr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_vld,
  input  logic [NTYPE-1:0]    frm_err,
  input  logic                enter_err,
  input  logic                leave_err,
  input  logic                hist_wr,
  input  logic [NTYPE-1:0]    hist_wdata,
  input  logic [NTYPE-1:0]    cnt_clr,
  output logic [NTYPE-1:0]    act_flags,
  output logic [NTYPE-1:0]    hist_flags,
  output logic                act_any,
  output logic                hist_any,
  output logic [NTYPE*CW-1:0] cnt_flat
);
  type_vec_t seen;

  efr_window #(.NT(NTYPE), .WIN(WIN)) u_win (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_err(frm_err), .seen_o(seen)
  );

  efr_banks #(.NT(NTYPE)) u_banks (
    .clk(clk), .rst(rst), .seen(seen), .enter_err(enter_err),
    .leave_err(leave_err), .hist_wr(hist_wr), .hist_wdata(hist_wdata),
    .act_q(act_flags), .hist_q(hist_flags), .act_any(act_any), .hist_any(hist_any)
  );

  genvar g;
  generate
    for (g = 0; g < NTYPE; g++) begin : g_cnt
      efr_sat_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .inc(frm_vld & frm_err[g]), .clr(cnt_clr[g]),
        .cnt(cnt_flat[g*CW +: CW])
      );
    end
  endgenerate

  // R7
  any_hist_chk: assert property (@(posedge clk) disable iff (rst)
    hist_any == (hist_flags != '0));
  // R7
  any_act_chk: assert property (@(posedge clk) disable iff (rst)
    act_any == (act_flags != '0));
endmodule

// File: tb/sim_err_flag_reg.sv
module sim_err_flag_reg;
  localparam int CLK_PER = 10;

  logic clk = 0, rst = 1;
  logic frm_vld = 0, enter_err = 0, leave_err = 0, hist_wr = 0;
  logic [3:0] frm_err = 0, hist_wdata = 0, cnt_clr = 0;
  logic [3:0] act_flags, hist_flags;
  logic act_any, hist_any;
  logic [31:0] cnt_flat;

  int n_cmp = 0, n_bad = 0;
  logic [3:0] m_win [16];
  logic [3:0] m_act = 0, m_hist = 0;
  int m_cnt [4];

  always #(CLK_PER/2) clk = ~clk;

  err_flag_reg u0 (.*);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " act"}, act_flags, m_act);
    chk({req, " hist"}, hist_flags, m_hist);
    chk("R7 act_any", act_any, m_act != 0);
    chk("R7 hist_any", hist_any, m_hist != 0);
    for (int i = 0; i < 4; i++) chk({req, " cnt"}, cnt_flat[i*8 +: 8], m_cnt[i]);
  endtask

  task automatic step(bit v, logic [3:0] e, bit en, bit lv, bit wr,
                      logic [3:0] wd, logic [3:0] cc);
    logic [3:0] seen, msk;
    frm_vld = v; frm_err = e; enter_err = en; leave_err = lv;
    hist_wr = wr; hist_wdata = wd; cnt_clr = cc;
    @(posedge clk);
    if (v) begin
      for (int k = 15; k > 0; k--) m_win[k] = m_win[k-1];
      m_win[0] = e;
    end
    seen = 0;
    for (int k = 0; k < 16; k++) seen |= m_win[k];
    msk = wr ? (~wd & ~m_act) : 4'h0;
    m_hist &= ~msk;
    if (en) begin m_act = seen; m_hist |= seen; end
    else if (lv) begin m_act = 0; m_hist = 0; end
    for (int i = 0; i < 4; i++) begin
      if (cc[i]) m_cnt[i] = 0;
      else if (v && e[i] && m_cnt[i] < 255) m_cnt[i]++;
    end
    @(negedge clk);
    frm_vld = 0; frm_err = 0; enter_err = 0; leave_err = 0;
    hist_wr = 0; hist_wdata = 0; cnt_clr = 0;
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) m_win[k] = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1");

    // R2 R8: sweep every error pattern through the window
    for (int p = 0; p < 16; p++) begin
      step(1, 4'(p), 0, 0, 0, 0, 0);
      check_all("R8");
    end
    // R2: no-valid frames do not count
    step(0, 4'hF, 0, 0, 0, 0, 0);
    check_all("R2");
    // R3: capture with every pattern, including the same-cycle frame
    for (int p = 0; p < 16; p++) begin
      step(1, 4'(p), 1, 0, 0, 0, 0);
      check_all("R3");
      step(0, 0, 0, 1, 0, 0, 0);
      check_all("R4");
    end
    // R2 window edge: one error then 15 clean frames
    step(1, 4'h1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 15; k++) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    check_all("R2 edge16");
    step(0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    check_all("R2 edge17");
    step(0, 0, 0, 1, 0, 0, 0);
    // R5: clear blocked by actual, allowed otherwise
    step(1, 4'h3, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 4'h0, 0);
    check_all("R5 blocked");
    for (int k = 0; k < 16; k++) step(1, 0, 0, 0, 0, 0, 0);
    step(1, 4'h4, 1, 0, 0, 0, 0);
    check_all("R3 recapture");
    step(0, 0, 0, 0, 1, 4'hE, 0);
    check_all("R5 partial");
    step(0, 0, 0, 0, 1, 4'hF, 0);
    check_all("R5 ones");
    // R6: clear of bit 1 with capture of bit 1 in same cycle
    step(1, 4'h2, 1, 0, 1, 4'h0, 0);
    check_all("R6");
    // R4: enter and leave together
    step(1, 4'h8, 1, 1, 0, 0, 0);
    check_all("R4 both");
    step(0, 0, 0, 1, 0, 0, 0);
    check_all("R4");
    // R9: saturation, clear, clear-over-increment
    for (int k = 0; k < 300; k++) step(1, 4'hF, 0, 0, 0, 0, 0);
    check_all("R9 sat");
    step(1, 4'hF, 0, 0, 0, 0, 4'h1);
    check_all("R9 clr");
    step(0, 0, 0, 0, 0, 0, 4'h6);
    check_all("R9 clr2");
    step(1, 4'h5, 0, 0, 0, 0, 0);
    check_all("R8 after clr");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule